// File: doc/BRIEF.md
# Stereo Volume and Click-Free Mute Gain Stage

This block scales a stream of signed stereo playback samples by a gain built from three factors: a volume attenuation chosen by a 6-bit code, a soft-mute ramp, and a converter power ramp. Neither mute nor the converter enable switches the output abruptly. Each one moves its own gain along a raised-cosine curve, one step at a time, as samples pass through the block. This keeps clicks out of the analog output when playback is silenced, resumed, started or stopped.

Samples arrive with a one-cycle valid strobe and leave the block four clock cycles later with their own valid strobe. The volume code is captured with each sample. Both ramps move only when a sample is accepted. A ramp can be reversed part way: when its request is withdrawn, it turns back from the step it has reached.

Top module: `gs_gain_stage`

## Requirements
- R1: The volume code sets the gain as follows. Codes 0 and 1 give 0 dB. Codes 2 to 51 give (code-1) dB of attenuation. Codes 52, 53, 54, 55 and 56 give 52, 54, 57, 60 and 66 dB. Codes 57 to 63 give a gain of exactly zero. A gain of A dB of attenuation is the factor 10^(-A/20).
- R2: Left and right channels get the same gain, so equal inputs give equal outputs.
- R3: Mute ramp. The ramp has step indices 0 to 32, and step k carries the gain (1-cos(pi*k/32))/2. Each step is held for 32 samples. Asserting `mute` lowers the step by one after every 32 accepted samples, down to 0 (1024 samples from full gain to silence). Releasing `mute` raises it the same way, up to 32.
- R4: Power ramp. This ramp uses the same curve with 4 samples per step (128 samples end to end). It rises while `dac_en` is 1 and falls while it is 0.
- R5: When a ramp's request changes part way through, the ramp keeps its current step and heads the other way. Its count of samples held at that step restarts from zero.
- R6: The output is the input multiplied by the volume gain and both ramp gains, rounded to nearest and saturated to the signed 24-bit range. Full gain returns the input exactly, including both rail values, and zero gain returns 0.
- R7: After reset, `out_valid` and both outputs are 0. The mute ramp starts at step 32 and the power ramp starts at step 0, so the output stays 0 until `dac_en` is raised.
- R8: Each accepted sample produces exactly one `out_valid` pulse, four clock cycles after its `in_valid`. The outputs hold their values between pulses.
- R9: The volume code is sampled together with each valid sample, so back-to-back samples can use different codes.
- R10: Ramp steps advance only on accepted samples. Control changes made while no samples arrive leave the ramp step where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| vol_code | input | 6 | Volume code, captured with each sample |
| mute | input | 1 | Soft-mute request (1 = ramp to silence) |
| dac_en | input | 1 | Converter enable (1 = ramp up, 0 = ramp down) |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Scaled left sample, signed |
| out_right | output | 24 | Scaled right sample, signed |

## Verification
Both ramps can be moving on the same sample. The mute and power ramps then scale the same sample, each at its own step and hold count. The bench provokes this by flipping `mute` and `dac_en` in the same idle cycle and then streaming samples back to back at a non-zero volume code. Each output is judged against the product of both cosine gains and the volume gain, computed from the step each ramp is expected to occupy. A separate case reverses the mute ramp in the middle of a step, to check that the hold count restarts.

// File: rtl/gs_pkg.sv
package gs_pkg;
  localparam int CH = 2;

  // Attenuation in dB for a volume code; -1 means silence.
  function automatic int vol_atten_db(input int code);
    if (code <= 1) return 0;
    if (code <= 51) return code - 1;
    case (code)
      52: return 52;
      53: return 54;
      54: return 57;
      55: return 60;
      56: return 66;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/gs_vol_rom.sv
module gs_vol_rom #(
  parameter int VOL_W = 6,
  parameter int FRAC  = 16,
  parameter int GW    = FRAC + 1
) (
  input  logic             clk,
  input  logic [VOL_W-1:0] addr,
  output logic [GW-1:0]    data
);
  localparam int DEPTH = 1 << VOL_W;
  logic [GW-1:0] rom [DEPTH];

  initial begin
    int  db;
    real g;
    for (int i = 0; i < DEPTH; i++) begin
      db = gs_pkg::vol_atten_db(i);
      if (db < 0) rom[i] = '0;
      else begin
        g      = $pow(10.0, -db / 20.0) * (2.0 ** FRAC);
        rom[i] = GW'($rtoi(g + 0.5));
      end
    end
  end

  always_ff @(posedge clk) data <= rom[addr];
endmodule

// File: rtl/gs_cos_rom.sv
module gs_cos_rom #(
  parameter int STEPS = 32,
  parameter int FRAC  = 16,
  parameter int GW    = FRAC + 1,
  parameter int AW    = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic [GW-1:0] data_a,
  output logic [GW-1:0] data_b
);
  localparam int DEPTH = STEPS + 1;
  localparam real PI = 3.14159265358979323846;
  logic [GW-1:0] rom [DEPTH];

  initial begin
    real g;
    for (int i = 0; i < DEPTH; i++) begin
      g      = (1.0 - $cos(PI * i / STEPS)) / 2.0 * (2.0 ** FRAC);
      rom[i] = GW'($rtoi(g + 0.5));
    end
  end

  always_ff @(posedge clk) begin
    data_a <= rom[addr_a];
    data_b <= rom[addr_b];
  end
endmodule

// File: rtl/gs_ramp_ctrl.sv
module gs_ramp_ctrl #(
  parameter int STEPS   = 32,
  parameter int HOLD    = 32,
  parameter bit INIT_UP = 1'b1,
  parameter int PW      = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt_up,
  input  logic          adv,
  output logic [PW-1:0] pos
);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [PW-1:0] TOP  = PW'(STEPS);
  localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

  logic          prev_up;
  logic [HW-1:0] sub;
  logic [HW-1:0] sub_base;
  logic          moving;

  always_comb begin
    sub_base = (tgt_up != prev_up) ? '0 : sub;
    moving   = tgt_up ? (pos != TOP) : (pos != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_up <= INIT_UP;
      pos     <= INIT_UP ? TOP : '0;
      sub     <= '0;
    end else begin
      prev_up <= tgt_up;
      if (adv && moving) begin
        if (sub_base == LAST) begin
          sub <= '0;
          pos <= tgt_up ? pos + 1'b1 : pos - 1'b1;
        end else begin
          sub <= sub_base + 1'b1;
        end
      end else begin
        sub <= sub_base;
      end
    end
  end
endmodule

// File: rtl/gs_gain_stage.sv
module gs_gain_stage #(
  parameter int DW         = 24,
  parameter int VOL_W      = 6,
  parameter int FRAC       = 16,
  parameter int RAMP_STEPS = 32,
  parameter int MUTE_HOLD  = 32,
  parameter int PWR_HOLD   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_left,
  input  logic signed [DW-1:0] in_right,
  input  logic [VOL_W-1:0]     vol_code,
  input  logic                 mute,
  input  logic                 dac_en,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_left,
  output logic signed [DW-1:0] out_right
);
  localparam int CH  = gs_pkg::CH;
  localparam int GW  = FRAC + 1;
  localparam int PW  = $clog2(RAMP_STEPS + 1);
  localparam int PW2 = 2 * GW;
  localparam int MW  = DW + GW + 1;
  localparam int SW  = MW - FRAC;
  localparam logic [PW2-1:0] HALF_G = PW2'(1) << (FRAC - 1);
  localparam longint HALF_INT = longint'(1) << (FRAC - 1);
  localparam logic signed [SW-1:0] SAT_HI = SW'((longint'(1) << (DW - 1)) - 1);
  localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;

  logic [PW-1:0] mute_pos, pwr_pos;
  logic [GW-1:0] vg1, mg1, pg1, vg2, rp2, gt3;
  logic [PW2-1:0] rprod, gprod;
  logic v1, v2, v3;
  logic signed [DW-1:0] x1 [CH];
  logic signed [DW-1:0] x2 [CH];
  logic signed [DW-1:0] x3 [CH];

  gs_ramp_ctrl #(.STEPS(RAMP_STEPS), .HOLD(MUTE_HOLD), .INIT_UP(1'b1), .PW(PW)) mute_ramp_i (
    .clk(clk), .rst(rst), .tgt_up(~mute), .adv(in_valid), .pos(mute_pos));

  gs_ramp_ctrl #(.STEPS(RAMP_STEPS), .HOLD(PWR_HOLD), .INIT_UP(1'b0), .PW(PW)) pwr_ramp_i (
    .clk(clk), .rst(rst), .tgt_up(dac_en), .adv(in_valid), .pos(pwr_pos));

  gs_vol_rom #(.VOL_W(VOL_W), .FRAC(FRAC), .GW(GW)) vol_rom_i (
    .clk(clk), .addr(vol_code), .data(vg1));

  gs_cos_rom #(.STEPS(RAMP_STEPS), .FRAC(FRAC), .GW(GW), .AW(PW)) cos_rom_i (
    .clk(clk), .addr_a(mute_pos), .addr_b(pwr_pos), .data_a(mg1), .data_b(pg1));

  always_comb begin
    rprod = PW2'(mg1) * PW2'(pg1) + HALF_G;
    gprod = PW2'(vg2) * PW2'(rp2) + HALF_G;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      v3 <= v2;
      out_valid <= v3;
    end
    x1[0] <= in_left;
    x1[1] <= in_right;
    x2    <= x1;
    x3    <= x2;
    rp2   <= rprod[FRAC +: GW];
    vg2   <= vg1;
    gt3   <= gprod[FRAC +: GW];
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic signed [MW-1:0] xs, gs, prod;
    logic signed [SW-1:0] sh;
    logic signed [DW-1:0] res, y_q;

    always_comb begin
      xs   = MW'(x3[c]);
      gs   = MW'({1'b0, gt3});
      prod = xs * gs + MW'(HALF_INT);
      sh   = prod[MW-1:FRAC];
      if (sh > SAT_HI)      res = SAT_HI[DW-1:0];
      else if (sh < SAT_LO) res = SAT_LO[DW-1:0];
      else                  res = sh[DW-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)     y_q <= '0;
      else if (v3) y_q <= res;
    end
  end

  assign out_left  = g_ch[0].y_q;
  assign out_right = g_ch[1].y_q;
endmodule

// File: rtl/gs_gain_stage_chk.sv
module gs_gain_stage_chk #(
  parameter int DW    = 24,
  parameter int VOL_W = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_left,
  input logic signed [DW-1:0] in_right,
  input logic [VOL_W-1:0]     vol_code,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_left,
  input logic signed [DW-1:0] out_right
);
  logic [2:0] age;
  logic       rst_seen;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst)             age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R7
  always @(negedge clk) begin
    if (rst_seen) begin
      reset_quiet_chk: assert (!out_valid && out_left == '0 && out_right == '0);
    end
  end

  // R8
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2 && !out_valid) |-> ($stable(out_left) && $stable(out_right)));

  // R2
  lr_match_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && out_valid && $past(in_left, 4) == $past(in_right, 4)) |-> (out_left == out_right));

  // R1
  full_atten_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && out_valid && int'($past(vol_code, 4)) >= 57) |-> (out_left == '0 && out_right == '0));

  // R6
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && out_valid && $past(in_left, 4) == '0) |-> (out_left == '0));
endmodule

bind gs_gain_stage gs_gain_stage_chk #(.DW(DW), .VOL_W(VOL_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
  .vol_code(vol_code), .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

// File: tb/gs_gain_stage_tb_top.sv
`timescale 1ns/1ps
module gs_gain_stage_tb_top;
  localparam int DW = 24;
  localparam int NMAX = 8192;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_left = '0;
  logic signed [DW-1:0] in_right = '0;
  logic [5:0] vol_code = '0;
  logic mute = 1'b0;
  logic dac_en = 1'b0;
  logic out_valid;
  logic signed [DW-1:0] out_left, out_right;

  always #10 clk = ~clk;

  gs_gain_stage dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .vol_code(vol_code), .mute(mute), .dac_en(dac_en),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behavioural model of both ramps
  int mpos = 32, msub = 0, ppos = 0, psub = 0;
  bit cur_mute = 1'b0, cur_en = 1'b0;

  longint exp_l [NMAX];
  longint exp_r [NMAX];
  longint tol_l [NMAX];
  longint tol_r [NMAX];
  int     exp_c [NMAX];
  string  exp_t [NMAX];
  int wr = 0, rd = 0;
  bit done = 1'b0;

  function automatic real vol_gain(input int code);
    if (code <= 1) return 1.0;
    if (code <= 51) return $pow(10.0, -(code - 1) / 20.0);
    case (code)
      52: return $pow(10.0, -52.0 / 20.0);
      53: return $pow(10.0, -54.0 / 20.0);
      54: return $pow(10.0, -57.0 / 20.0);
      55: return $pow(10.0, -60.0 / 20.0);
      56: return $pow(10.0, -66.0 / 20.0);
      default: return 0.0;
    endcase
  endfunction

  function automatic real rc(input int k);
    return (1.0 - $cos(PI * k / 32.0)) / 2.0;
  endfunction

  function automatic longint tol_of(input longint x, input real g);
    if (g == 1.0 || g == 0.0) return 0;
    return ((x < 0) ? -x : x) / 8192 + 4;
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint expv, input longint tol);
    longint d;
    n_chk++;
    d = act - expv;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", tag, what, act, expv, tol);
    end
  endtask

  task automatic send(input int l, input int r, input int code, input string tag);
    real g;
    g = vol_gain(code) * rc(mpos) * rc(ppos);
    @(negedge clk);
    in_valid = 1'b1;
    in_left  = DW'(l);
    in_right = DW'(r);
    vol_code = 6'(code);
    exp_l[wr] = longint'(real'(l) * g);
    exp_r[wr] = longint'(real'(r) * g);
    tol_l[wr] = tol_of(l, g);
    tol_r[wr] = tol_of(r, g);
    exp_c[wr] = cyc;
    exp_t[wr] = tag;
    wr++;
    if (!cur_mute ? (mpos < 32) : (mpos > 0)) begin
      if (msub == 31) begin msub = 0; mpos += cur_mute ? -1 : 1; end
      else msub++;
    end
    if (cur_en ? (ppos < 32) : (ppos > 0)) begin
      if (psub == 3) begin psub = 0; ppos += cur_en ? 1 : -1; end
      else psub++;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic set_ctrl(input bit m, input bit e);
    @(negedge clk);
    in_valid = 1'b0;
    if (m != cur_mute) msub = 0;
    if (e != cur_en) psub = 0;
    mute = m;
    dac_en = e;
    cur_mute = m;
    cur_en = e;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (rd >= wr) begin
        n_chk++;
        n_bad++;
        $display("FAIL R8 extra pulse: actual out_valid 1 expected 0");
      end else begin
        check("R8", "latency", longint'(cyc - exp_c[rd]), 4, 0);
        check(exp_t[rd], "left", longint'(out_left), exp_l[rd], tol_l[rd]);
        check(exp_t[rd], "right", longint'(out_right), exp_r[rd], tol_r[rd]);
        rd++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R8 watchdog: actual running expected finished");
    report();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check("R7", "out_valid", longint'(out_valid), 0, 0);
    check("R7", "out_left", longint'(out_left), 0, 0);
    check("R7", "out_right", longint'(out_right), 0, 0);
    for (int i = 0; i < 5; i++) send(1000000, -1000000, 0, "R7");

    // R4 power roll-up
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 140; i++) send(8000000, -6000000, 0, "R4");

    // R1 full code sweep, R2 equal channels
    for (int c = 0; c < 64; c++) send(8000000, -5000000, c, "R1");
    for (int c = 0; c < 64; c++) send(3000000, 3000000, c, "R2");

    // R9 code changes on back-to-back samples
    for (int i = 0; i < 20; i++) send(7000000, 7000000, (i % 2) ? 0 : 40, "R9");

    // R10 idle after mute request, then R3 full roll-down and roll-up
    set_ctrl(1'b1, 1'b1);
    idle(40);
    for (int i = 0; i < 1060; i++) send(7000000, -3000000, 0, (i < 32) ? "R10" : "R3");
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 1060; i++) send(7000000, -3000000, 0, "R3");

    // R5 reversal mid-ramp and mid-step
    set_ctrl(1'b1, 1'b1);
    for (int i = 0; i < 300; i++) send(6000000, -6000000, 0, "R5");
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 400; i++) send(6000000, -6000000, 0, "R5");
    set_ctrl(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) send(6000000, -6000000, 0, "R5");
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 40; i++) send(6000000, -6000000, 0, "R5");

    // R6 both ramps moving together, with volume
    set_ctrl(1'b1, 1'b0);
    for (int i = 0; i < 200; i++) send(8000000, -7000000, 10, "R6");
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 1100; i++) send(8000000, -7000000, 5, "R6");

    // R6 rails at full gain
    for (int i = 0; i < 4; i++) send(8388607, -8388608, 0, "R6");

    // R4 power roll-down
    set_ctrl(1'b0, 1'b0);
    for (int i = 0; i < 140; i++) send(8000000, -6000000, 0, "R4");

    idle(12);
    check("R8", "samples out", longint'(rd), longint'(wr), 0);
    done = 1'b1;
    report();
    $finish;
  end
endmodule